// File: doc/BRIEF.md
# Boot-Sector NOR Flash Range Eraser

This block erases a contiguous run of sectors in a 16-bit parallel NOR flash bank of 2 MiB. The bank has eleven sectors of unequal size: a small boot area at the bottom made of one 16 KiB sector, two 8 KiB sectors and one 224 KiB sector, followed by seven 256 KiB sectors. A requester gives a first and a last sector index and pulses `start`. The block checks the request and the per-sector write-protect mask. For each sector in the range it then issues the standard two-stage unlock and erase command writes on a simple word-addressed write/read bus. It polls the sector until the device reports completion, and returns the device to read-array mode.

While the block works, `busy` is high. It rejects a malformed range or a range that touches a protected sector at once, with no bus traffic. A sector that does not finish within a cycle-count limit aborts the rest of the range. After the last bus write the block waits a settle interval of a set number of cycles. It then raises `done` with a two-bit result code, and that code stays valid until the next accepted `start`. The protect mask is a small register: it resets with the boot area guarded and can be rewritten while the block is idle.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset `busy` and `done` are low, no bus strobe is active, and `prot_val` equals the parameter `PROT_RESET` (default 11'h00F, sectors 0 to 3 protected; bit n guards sector n).
- R2: A request whose first index is negative, whose first index exceeds its last index, or whose last index is 11 or more ends with result 1 (invalid) and no bus write or read.
- R3: A valid request in which any sector from first to last has its protect bit set ends with result 2 (protected) and no bus write or read.
- R4: For every sector the block writes, in order, 0x00AA to word address 0x555, 0x0055 to 0x2AA, 0x0080 to 0x555, 0x00AA to 0x555, 0x0055 to 0x2AA, and 0x0030 to the sector's start word address.
- R5: Sector start word addresses are 0x00000, 0x02000, 0x03000 and 0x04000 for sectors 0 to 3, and 0x20000 + 0x20000*(n-4) for sectors n = 4 to 10 (byte offsets halved).
- R6: After the confirm write, every read strobe carries the start address of the sector being erased. The sector counts as erased in the first poll whose read data has bit 7 set. Read data is taken in the second cycle after the read strobe.
- R7: Each sector's work ends with one write of 0x00F0 to word address 0x555, whether the sector completed or timed out.
- R8: If bit 7 is still clear after `TIMEOUT_CYC` cycles of polling, the block writes 0x00F0 to 0x555, erases no further sector, and ends with result 3 (timeout). A range that completes ends with result 0 (ok).
- R9: `done` rises no sooner than `SETTLE_CYC` cycles after the last bus write of an erase run.
- R10: While `done` is high and `start` is low, `done` and `result` hold. A `start` pulse while `busy` is high is ignored.
- R11: A write to the protect register (`prot_we`) loads `prot_wval` while idle. While `busy` is high the write is ignored.
- R12: Write and read strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| first_sec | input | IDX_W (5) | First sector index, signed |
| last_sec | input | IDX_W (5) | Last sector index, signed |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid, held until the next start |
| result | output | 2 | 0 ok, 1 invalid, 2 protected, 3 timeout |
| prot_we | input | 1 | Protect mask write strobe |
| prot_wval | input | NSECT (11) | New protect mask |
| prot_val | output | NSECT (11) | Current protect mask |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W (20) | Flash word address |
| fl_wdata | output | DATA_W (16) | Flash write data |
| fl_rdata | input | DATA_W (16) | Flash read data, valid two cycles after `fl_re` |

## Verification
Assertions check on every cycle that write and read strobes never overlap, that no erase confirm ever targets a protected sector, that `busy` and `done` are exclusive, that a held result does not change, that the protect mask is frozen while busy, and that the interval counters stay in range. The bench scenarios cover the rest: the exact order and content of the command writes for each sector, the address map, the choice between reject codes, the abort after a timed-out sector, and the length of the settle wait. A behavioural flash stub with a chosen erase latency per sector makes these visible.

// File: rtl/nes_pkg.sv
package nes_pkg;

  localparam int NSECT = 11;

  typedef enum logic [1:0] {
    RES_OK        = 2'd0,
    RES_INVALID   = 2'd1,
    RES_PROTECTED = 2'd2,
    RES_TIMEOUT   = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_CMD, S_POLL_RD, S_POLL_WAIT, S_POLL_CHK, S_RST_WR, S_SETTLE
  } state_e;

  localparam int UNLOCK_HI = 32'h555;
  localparam int UNLOCK_LO = 32'h2AA;
  localparam int DATA_READ_ARRAY = 32'hF0;

  // word start address of sector n (byte offset halved)
  function automatic int sect_word_base(input int n);
    int byte_off;
    if (n == 0)      byte_off = 0;
    else if (n <= 2) byte_off = 32'h4000 + 32'h2000 * (n - 1);
    else if (n == 3) byte_off = 32'h8000;
    else             byte_off = 32'h40000 * (n - 3);
    return byte_off >> 1;
  endfunction

  // command step 0..4 address (step 5 goes to the sector base)
  function automatic int cmd_addr(input int step);
    return (step == 1 || step == 4) ? UNLOCK_LO : UNLOCK_HI;
  endfunction

  function automatic int cmd_data(input int step);
    case (step)
      0, 3:    return 32'hAA;
      1, 4:    return 32'h55;
      2:       return 32'h80;
      default: return 32'h30;
    endcase
  endfunction

endpackage

// File: rtl/nes_cycle_timer.sv
module nes_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  // R9: counter saturates at its limit and never wraps
  a_r9_timer_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
  a_r9_timer_sat: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);
endmodule

// File: rtl/nes_protect_reg.sv
module nes_protect_reg #(
  parameter int NS = 11,
  parameter logic [NS-1:0] RESET_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          lock,
  input  logic [NS-1:0] wval,
  output logic [NS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else if (we && !lock) q <= wval;
  end

  // R11: mask frozen while the sequencer holds it locked
  a_r11_locked: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(q));
endmodule

// File: rtl/nes_sector_map.sv
module nes_sector_map
  import nes_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 20,
  parameter int NS     = NSECT
) (
  input  logic signed [IDX_W-1:0]   first_i,
  input  logic signed [IDX_W-1:0]   last_i,
  input  logic [$clog2(NS)-1:0]     cur_i,
  output logic                      range_ok,
  output logic [NS-1:0]             range_mask,
  output logic [ADDR_W-1:0]         cur_base
);
  logic [ADDR_W-1:0] base_tbl [NS];

  for (genvar g = 0; g < NS; g++) begin : g_sect
    assign base_tbl[g]   = ADDR_W'(sect_word_base(g));
    assign range_mask[g] = (int'(first_i) <= g) && (g <= int'(last_i));
  end

  assign range_ok = (first_i >= 0) && (first_i <= last_i) && (int'(last_i) < NS);
  assign cur_base = (int'(cur_i) < NS) ? base_tbl[cur_i] : '0;
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nes_pkg::*;
#(
  parameter int IDX_W       = 5,
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int DONE_BIT    = 7,
  parameter int TIMEOUT_CYC = 50_000_000,
  parameter int SETTLE_CYC  = 1_000_000,
  parameter logic [NSECT-1:0] PROT_RESET = 11'h00F
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic signed [IDX_W-1:0] first_sec,
  input  logic signed [IDX_W-1:0] last_sec,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              result,
  input  logic                    prot_we,
  input  logic [NSECT-1:0]        prot_wval,
  output logic [NSECT-1:0]        prot_val,
  output logic                    fl_we,
  output logic                    fl_re,
  output logic [ADDR_W-1:0]       fl_addr,
  output logic [DATA_W-1:0]       fl_wdata,
  input  logic [DATA_W-1:0]       fl_rdata
);
  localparam int SW = $clog2(NSECT);
  localparam logic [DATA_W-1:0] DONE_MASK = DATA_W'(1) << DONE_BIT;
  localparam logic [DATA_W-1:0] CONFIRM   = DATA_W'(cmd_data(5));

  state_e                  state;
  logic signed [IDX_W-1:0] req_first, req_last;
  logic [SW-1:0]           cur;
  logic [2:0]              step;
  logic                    tmo_flag;
  logic                    range_ok;
  logic [NSECT-1:0]        range_mask;
  logic [ADDR_W-1:0]       cur_base;
  logic                    tmo_exp, settle_exp;
  logic                    poll_active;

  nes_sector_map #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .NS(NSECT)) u_map (
    .first_i(req_first), .last_i(req_last), .cur_i(cur),
    .range_ok(range_ok), .range_mask(range_mask), .cur_base(cur_base)
  );

  nes_protect_reg #(.NS(NSECT), .RESET_VAL(PROT_RESET)) u_prot (
    .clk(clk), .rst(rst), .we(prot_we), .lock(busy),
    .wval(prot_wval), .q(prot_val)
  );

  assign poll_active = (state == S_POLL_RD) || (state == S_POLL_WAIT) || (state == S_POLL_CHK);

  nes_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst(rst),
    .clr(state == S_CMD && step == 3'd5),
    .en(poll_active), .expired(tmo_exp)
  );

  nes_cycle_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst),
    .clr(state == S_RST_WR || state == S_CHECK),
    .en(state == S_SETTLE), .expired(settle_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= RES_OK;
      fl_we     <= 1'b0;
      fl_re     <= 1'b0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
      req_first <= '0;
      req_last  <= '0;
      cur       <= '0;
      step      <= '0;
      tmo_flag  <= 1'b0;
    end else begin
      fl_we <= 1'b0;
      fl_re <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          busy      <= 1'b1;
          done      <= 1'b0;
          req_first <= first_sec;
          req_last  <= last_sec;
          state     <= S_CHECK;
        end
        S_CHECK: begin
          tmo_flag <= 1'b0;
          step     <= '0;
          if (!range_ok) begin
            result <= RES_INVALID;
            busy   <= 1'b0;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else if (|(range_mask & prot_val)) begin
            result <= RES_PROTECTED;
            busy   <= 1'b0;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else begin
            cur   <= req_first[SW-1:0];
            state <= S_CMD;
          end
        end
        S_CMD: begin
          fl_we <= 1'b1;
          if (step == 3'd5) begin
            fl_addr  <= cur_base;
            fl_wdata <= CONFIRM;
            step     <= '0;
            state    <= S_POLL_RD;
          end else begin
            fl_addr  <= ADDR_W'(cmd_addr(int'(step)));
            fl_wdata <= DATA_W'(cmd_data(int'(step)));
            step     <= step + 3'd1;
          end
        end
        S_POLL_RD: begin
          fl_re   <= 1'b1;
          fl_addr <= cur_base;
          state   <= S_POLL_WAIT;
        end
        S_POLL_WAIT: state <= S_POLL_CHK;
        S_POLL_CHK: begin
          if ((fl_rdata & DONE_MASK) != '0) begin
            state <= S_RST_WR;
          end else if (tmo_exp) begin
            tmo_flag <= 1'b1;
            state    <= S_RST_WR;
          end else begin
            state <= S_POLL_RD;
          end
        end
        S_RST_WR: begin
          fl_we    <= 1'b1;
          fl_addr  <= ADDR_W'(UNLOCK_HI);
          fl_wdata <= DATA_W'(DATA_READ_ARRAY);
          if (tmo_flag) begin
            result <= RES_TIMEOUT;
            state  <= S_SETTLE;
          end else if (cur == req_last[SW-1:0]) begin
            result <= RES_OK;
            state  <= S_SETTLE;
          end else begin
            cur   <= cur + 1'b1;
            state <= S_CMD;
          end
        end
        S_SETTLE: if (settle_exp) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: strobes are exclusive
  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));
  // R3: an erase confirm never reaches a protected sector
  a_r3_no_protected_confirm: assert property (@(posedge clk) disable iff (rst)
    (fl_we && fl_wdata == CONFIRM) |-> !prot_val[cur]);
  // R10: result and done hold until a new start
  a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(result)));
  // R1: busy and done are never both high
  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R2: a rejected request produces no strobe
  a_r2_no_bus_on_reject: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHECK && !range_ok) |=> (!fl_we && !fl_re));
endmodule

// File: tb/nor_erase_seq_test.sv
`timescale 1ns/1ps
module nor_erase_seq_test;
  localparam int NS   = 11;
  localparam int TMO  = 64;
  localparam int SET  = 20;
  localparam int SLOW = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [4:0] first_sec = '0, last_sec = '0;
  logic busy, done;
  logic [1:0] result;
  logic prot_we = 1'b0;
  logic [NS-1:0] prot_wval = '0;
  logic [NS-1:0] prot_val;
  logic fl_we, fl_re;
  logic [19:0] fl_addr;
  logic [15:0] fl_wdata;
  logic [15:0] fl_rdata = '0;

  always #2.5 clk = ~clk;

  nor_erase_seq #(.TIMEOUT_CYC(TMO), .SETTLE_CYC(SET)) uut (
    .clk(clk), .rst(rst), .start(start), .first_sec(first_sec), .last_sec(last_sec),
    .busy(busy), .done(done), .result(result),
    .prot_we(prot_we), .prot_wval(prot_wval), .prot_val(prot_val),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int lat [NS];
  int log_n = 0, rd_n = 0, rd_bad = 0, overlap = 0, last_wr_cyc = 0;
  logic [19:0] log_a [128];
  logic [15:0] log_d [128];
  logic [19:0] conf_addr = '0;
  int erase_left = 0;
  int exp_n, exp_res;
  logic [19:0] exp_a [128];
  logic [15:0] exp_d [128];

  // independent map: cumulative sizes in KiB, halved to words
  function automatic logic [19:0] ref_base(input int n);
    int kib = 0;
    for (int i = 0; i < n; i++)
      kib += (i == 0) ? 16 : (i <= 2) ? 8 : (i == 3) ? 224 : 256;
    return 20'((kib * 1024) / 2);
  endfunction

  function automatic int ref_sect(input logic [19:0] a);
    for (int i = 0; i < NS; i++) if (ref_base(i) == a) return i;
    return -1;
  endfunction

  // flash stub and bus monitor
  always @(posedge clk) begin
    cyc++;
    if (fl_we && fl_re) overlap++;
    if (erase_left > 0) erase_left--;
    if (fl_re) begin
      rd_n++;
      if (fl_addr != conf_addr) rd_bad++;
      fl_rdata <= (erase_left != 0) ? 16'h0000 : 16'hFFFF;
    end
    if (fl_we) begin
      if (log_n < 128) begin log_a[log_n] = fl_addr; log_d[log_n] = fl_wdata; end
      log_n++;
      last_wr_cyc = cyc;
      if (fl_wdata == 16'h0030 && ref_sect(fl_addr) >= 0) begin
        conf_addr = fl_addr;
        erase_left = lat[ref_sect(fl_addr)];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic void build_expect(input int f, input int l, input logic [NS-1:0] p);
    exp_n = 0;
    if (f < 0 || f > l || l >= NS) begin exp_res = 1; return; end
    for (int s = f; s <= l; s++) if (p[s]) begin exp_res = 2; return; end
    exp_res = 0;
    for (int s = f; s <= l; s++) begin
      exp_a[exp_n] = 20'h555; exp_d[exp_n] = 16'h00AA; exp_n++;
      exp_a[exp_n] = 20'h2AA; exp_d[exp_n] = 16'h0055; exp_n++;
      exp_a[exp_n] = 20'h555; exp_d[exp_n] = 16'h0080; exp_n++;
      exp_a[exp_n] = 20'h555; exp_d[exp_n] = 16'h00AA; exp_n++;
      exp_a[exp_n] = 20'h2AA; exp_d[exp_n] = 16'h0055; exp_n++;
      exp_a[exp_n] = ref_base(s); exp_d[exp_n] = 16'h0030; exp_n++;
      exp_a[exp_n] = 20'h555; exp_d[exp_n] = 16'h00F0; exp_n++;
      if (lat[s] >= TMO) begin exp_res = 3; return; end
    end
  endfunction

  task automatic set_prot(input logic [NS-1:0] v);
    @(negedge clk); prot_we = 1'b1; prot_wval = v;
    @(negedge clk); prot_we = 1'b0;
  endtask

  task automatic run(input int f, input int l, input string tag);
    int t0, mism;
    build_expect(f, l, prot_val);
    log_n = 0; rd_n = 0; rd_bad = 0;
    @(negedge clk);
    first_sec = 5'(f); last_sec = 5'(l); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t0 = cyc;
    while (!done && cyc - t0 < 20000) @(negedge clk);
    check(result == 2'(exp_res), {tag, " R8 result code"}, result, exp_res);
    check(log_n == exp_n, {tag, " R2 R3 write count"}, log_n, exp_n);
    mism = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (mism < 0 && (log_a[i] != exp_a[i] || log_d[i] != exp_d[i])) mism = i;
    check(mism < 0, {tag, " R4 R5 R7 write sequence"},
          (mism < 0) ? 0 : int'({log_a[mism], log_d[mism]}),
          (mism < 0) ? 0 : int'({exp_a[mism], exp_d[mism]}));
    check(rd_bad == 0, {tag, " R6 poll address"}, rd_bad, 0);
    if (exp_res == 0 || exp_res == 3) begin
      check(cyc - last_wr_cyc >= SET, {tag, " R9 settle gap"}, cyc - last_wr_cyc, SET);
      check(rd_n > 0, {tag, " R6 polls issued"}, rd_n, 1);
    end else begin
      check(rd_n == 0, {tag, " R2 R3 no reads"}, rd_n, 0);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    check(1'b0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f, l;
    logic [1:0] r0;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < NS; i++) lat[i] = 5 + i;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1 busy/done idle", {busy, done}, 0);
    check(prot_val == 11'h00F, "R1 protect reset", prot_val, 11'h00F);
    check(!fl_we && !fl_re, "R1 strobes idle", {fl_we, fl_re}, 0);

    run(4, 6, "dir-ok");
    run(-1, 3, "R2 negative first");
    run(7, 5, "R2 first>last");
    run(9, 11, "R2 last too big");
    run(2, 5, "R3 default protect");

    // R11 protect write while idle
    set_prot('0);
    check(prot_val == '0, "R11 protect write idle", prot_val, 0);
    run(0, 3, "R5 boot sectors");
    run(10, 10, "R5 top sector");

    // R8 timeout aborts the range
    lat[5] = SLOW;
    run(4, 7, "R8 timeout");
    lat[5] = 8;

    // R10 hold after done, start while busy ignored, R11 ignored while busy
    r0 = result;
    repeat (10) @(negedge clk);
    check(done && result == r0, "R10 result held", result, r0);
    log_n = 0;
    @(negedge clk); first_sec = 5'sd8; last_sec = 5'sd8; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    first_sec = -5'sd1; last_sec = 5'sd0; start = 1'b1;
    prot_we = 1'b1; prot_wval = 11'h7FF;
    @(negedge clk); start = 1'b0; prot_we = 1'b0;
    while (!done) @(negedge clk);
    check(result == 2'd0, "R10 start while busy ignored", result, 0);
    check(log_n == 7, "R10 single sector written", log_n, 7);
    check(prot_val == '0, "R11 write ignored while busy", prot_val, 0);

    // random mix
    for (int it = 0; it < 30; it++) begin
      if ($urandom_range(0, 3) == 0) set_prot(NS'($urandom) & NS'($urandom));
      for (int i = 0; i < NS; i++)
        lat[i] = ($urandom_range(0, 12) == 0) ? SLOW : $urandom_range(1, 20);
      f = $urandom_range(0, 14) - 2;
      l = $urandom_range(0, 13) - 1;
      run(f, l, "random");
    end

    check(overlap == 0, "R12 strobe overlap", overlap, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule